// File: doc/BRIEF.md
# Segmented Stream Summation Unit

This block reduces a finite integer stream to a shorter one. It accepts a stream of `IN_LEN` unsigned elements on a valid/ready input port. It adds every run of `SEG_LEN = IN_LEN/OUT_LEN` consecutive elements and delivers one sum per run on a valid/ready output port. When `OUT_LEN` is 1, the whole stream collapses to a single total. When `OUT_LEN` equals `IN_LEN`, each element passes through on its own.

A wrapping position counter marks where each run starts, so no divider or modulo logic is built. The first element of a run is written straight into the accumulator, and the others are added to it. A run's total is handed to the output slot when the next run's first element arrives. A second counter, over the whole stream, detects the final element, so the last total is flushed without waiting for more input. Output back-pressure stalls the input port, so a finished total is never lost.

Top module: `segsum_reducer`

## Requirements
- R1: Output number k (counting from 0) equals the sum of input elements k·SEG_LEN through k·SEG_LEN+SEG_LEN−1 of the current stream. Elements and sums are unsigned.
- R2: A stream of exactly IN_LEN accepted elements yields exactly OUT_LEN output transfers, and no further output appears while the input stays idle.
- R3: The first element of every run replaces the accumulator contents, so no value carries over between runs or between streams.
- R4: For every run except the last, the output valid rises in the cycle after the next run's first element is accepted, provided the output slot is free.
- R5: With the output ready held high, the last run's total is valid two cycles after the stream's final element is accepted, with no further input needed.
- R6: While the output is valid and not ready, the output data holds steady and the input ready is low.
- R7: In the cycle after the stream's final element is accepted, the input ready is low until the final total has been moved into the output slot.
- R8: A synchronous active-high reset drops the output valid, raises the input ready and discards any partial stream, so the next stream starts at element 0.
- R9: Sums are DATA_W+ceil(log2(SEG_LEN)) bits wide and never wrap. An all-ones run yields SEG_LEN·(2^DATA_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input stream element |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Input element can be taken this cycle |
| out_data | output | DATA_W+clog2(SEG_LEN) | Run total |
| out_valid | output | 1 | Run total offered |
| out_ready | input | 1 | Downstream takes the run total |

## Verification
The checker assumes that each stream has exactly IN_LEN accepted elements before the next stream begins, or else is cut short by reset. Its pending-run count relies on this.

It also assumes that the consumer may hold `out_ready` low for any length of time without breaking the input handshake rules. The directed stimulus supplies exactly IN_LEN elements per stream and uses reset only between streams or to abandon one on purpose. It mixes input gaps and output stalls in fixed patterns, so both back-pressure paths are exercised while the stream length contract still holds.

// File: rtl/segsum_pkg.sv
package segsum_pkg;

   // Width of a counter that must reach n-1, never below one bit.
   function automatic int cnt_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/segsum_wrap_cnt.sv
module segsum_wrap_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic at_zero,
   output logic at_last
);
   localparam int CW = segsum_pkg::cnt_width(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("segsum_wrap_cnt: LIMIT must be at least 1");
      end

      if (LIMIT == 1) begin : g_single
         // Every step is both the first and the last position.
         assign at_zero = 1'b1;
         assign at_last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] pos_q;

         always_ff @(posedge clk) begin
            if (rst)
               pos_q <= '0;
            else if (step)
               pos_q <= at_last ? '0 : pos_q + 1'b1;
         end

         assign at_zero = (pos_q == '0);
         assign at_last = (pos_q == CW'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/segsum_accum.sv
module segsum_accum #(
   parameter int DIN_W = 16,
   parameter int ACC_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             add,
   input  logic [DIN_W-1:0] din,
   output logic [ACC_W-1:0] acc
);
   generate
      if (ACC_W < DIN_W) begin : g_bad_width
         $error("segsum_accum: ACC_W narrower than DIN_W");
      end
   endgenerate

   logic [ACC_W-1:0] din_ext;
   assign din_ext = ACC_W'(din);

   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else if (load)
         acc <= din_ext;
      else if (add)
         acc <= acc + din_ext;
   end

endmodule

// File: rtl/segsum_out_slot.sv
module segsum_out_slot #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         capture,
   input  logic [W-1:0] din,
   input  logic         take,
   output logic         free,
   output logic         valid,
   output logic [W-1:0] data
);
   assign free = !valid || take;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (capture) begin
         valid <= 1'b1;
         data  <= din;
      end else if (take) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/segsum_reducer.sv
module segsum_reducer #(
   parameter int DATA_W  = 16,
   parameter int IN_LEN  = 12,
   parameter int OUT_LEN = 3,
   localparam int SEG_LEN = IN_LEN / OUT_LEN,
   localparam int SUM_W   = DATA_W + $clog2(SEG_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [SUM_W-1:0]  out_data,
   output logic              out_valid,
   input  logic              out_ready
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("segsum_reducer: DATA_W must be positive");
      end
      if (OUT_LEN < 1 || IN_LEN < OUT_LEN) begin : g_bad_lengths
         $error("segsum_reducer: need 1 <= OUT_LEN <= IN_LEN");
      end
      if ((IN_LEN % OUT_LEN) != 0) begin : g_bad_ratio
         $error("segsum_reducer: IN_LEN must be a multiple of OUT_LEN");
      end
   endgenerate

   logic             take_in;
   logic             run_start;
   logic             run_end_unused;
   logic             stream_start;
   logic             stream_end;
   logic             emit_mid;
   logic             flush_pend;
   logic             flush_fire;
   logic             slot_free;
   logic [SUM_W-1:0] acc;

   assign take_in  = in_valid && in_ready;
   assign in_ready = slot_free && !flush_pend;

   // Position inside the current run.
   segsum_wrap_cnt #(.LIMIT(SEG_LEN)) u_run_pos (
      .clk     (clk),
      .rst     (rst),
      .step    (take_in),
      .at_zero (run_start),
      .at_last (run_end_unused)
   );

   // Position inside the whole stream.
   segsum_wrap_cnt #(.LIMIT(IN_LEN)) u_stream_pos (
      .clk     (clk),
      .rst     (rst),
      .step    (take_in),
      .at_zero (stream_start),
      .at_last (stream_end)
   );

   segsum_accum #(.DIN_W(DATA_W), .ACC_W(SUM_W)) u_accum (
      .clk  (clk),
      .rst  (rst),
      .load (take_in && run_start),
      .add  (take_in && !run_start),
      .din  (in_data),
      .acc  (acc)
   );

   // A new run opening mid-stream releases the previous run's total.
   assign emit_mid   = take_in && run_start && !stream_start;
   assign flush_fire = flush_pend && slot_free;

   always_ff @(posedge clk) begin
      if (rst)
         flush_pend <= 1'b0;
      else if (take_in && stream_end)
         flush_pend <= 1'b1;
      else if (flush_fire)
         flush_pend <= 1'b0;
   end

   segsum_out_slot #(.W(SUM_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .capture (emit_mid || flush_fire),
      .din     (acc),
      .take    (out_ready),
      .free    (slot_free),
      .valid   (out_valid),
      .data    (out_data)
   );

endmodule

// File: rtl/segsum_reducer_chk.sv
module segsum_reducer_chk #(
   parameter int DATA_W  = 16,
   parameter int IN_LEN  = 12,
   parameter int OUT_LEN = 3,
   localparam int SEG_LEN = IN_LEN / OUT_LEN,
   localparam int SUM_W   = DATA_W + $clog2(SEG_LEN)
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] in_data,
   input logic              in_valid,
   input logic              in_ready,
   input logic [SUM_W-1:0]  out_data,
   input logic              out_valid,
   input logic              out_ready
);
   localparam longint MAX_SUM = longint'(SEG_LEN) * ((longint'(1) << DATA_W) - 1);

   logic acc_in;
   int   run_c;
   int   strm_c;
   int   pend;
   logic rst_q = 1'b0;

   assign acc_in = in_valid && in_ready;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         run_c  <= 0;
         strm_c <= 0;
         pend   <= 0;
      end else begin
         if (acc_in) begin
            run_c  <= (run_c == SEG_LEN - 1) ? 0 : run_c + 1;
            strm_c <= (strm_c == IN_LEN - 1) ? 0 : strm_c + 1;
         end
         pend <= pend + ((acc_in && run_c == SEG_LEN - 1) ? 1 : 0)
                      - ((out_valid && out_ready) ? 1 : 0);
      end
   end

   // R8: the cycle after reset shows an empty, ready block.
   always_ff @(posedge clk) begin
      if (rst_q && !rst)
         p_reset_clear_r8: assert (!out_valid && in_ready);
   end

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> pend > 0);

   p_emit_mid_r4: assert property (@(posedge clk) disable iff (rst)
      (acc_in && run_c == 0 && strm_c != 0) |=> out_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_backpress_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   p_final_block_r7: assert property (@(posedge clk) disable iff (rst)
      (acc_in && strm_c == IN_LEN - 1) |=> !in_ready);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> longint'(out_data) <= MAX_SUM);

endmodule

bind segsum_reducer segsum_reducer_chk #(
   .DATA_W  (DATA_W),
   .IN_LEN  (IN_LEN),
   .OUT_LEN (OUT_LEN)
) u_chk (.*);

// File: tb/segsum_reducer_bench.sv
`timescale 1ns/100ps
module segsum_reducer_bench;
   localparam int DATA_W  = 16;
   localparam int IN_LEN  = 12;
   localparam int OUT_LEN = 3;
   localparam int SEG_LEN = IN_LEN / OUT_LEN;
   localparam int SUM_W   = DATA_W + $clog2(SEG_LEN);
   localparam longint MASK = (longint'(1) << DATA_W) - 1;

   logic              clk = 1'b0;
   logic              rst;
   logic [DATA_W-1:0] in_data;
   logic              in_valid;
   logic              in_ready;
   logic [SUM_W-1:0]  out_data;
   logic              out_valid;
   logic              out_ready;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   segsum_reducer #(.DATA_W(DATA_W), .IN_LEN(IN_LEN), .OUT_LEN(OUT_LEN)) u_segsum_reducer (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint elem(input int pat, input int i);
      case (pat)
         0:       return longint'(i + 1);
         1:       return MASK;
         2:       return (longint'(i) * 37 + 5) & MASK;
         default: return (MASK - longint'(i) * 1000) & MASK;
      endcase
   endfunction

   task automatic run_stream(input int pat, input bit gaps, input bit stalls, input bit timing);
      longint got[OUT_LEN];
      int     first_cyc[OUT_LEN];
      int     acc_cyc[IN_LEN];
      int     idx = 0;
      int     nout = 0;
      int     cyc = 0;
      bit     seen = 1'b0;
      bit     prev_stall = 1'b0;
      longint prev_data = 0;
      int     extra = 0;
      while (nout < OUT_LEN && cyc < 2000) begin
         @(negedge clk);
         in_valid  = (idx < IN_LEN) && !(gaps && (cyc % 3 == 1));
         in_data   = (idx < IN_LEN) ? DATA_W'(elem(pat, idx)) : '0;
         out_ready = !(stalls && (cyc % 7 < 4));
         #1;
         if (prev_stall)
            check(out_valid && longint'(out_data) == prev_data, "R6 hold", longint'(out_data), prev_data);
         if (out_valid && !out_ready)
            check(!in_ready, "R6 backpressure", longint'(in_ready), 0);
         if (timing && idx == IN_LEN && cyc == acc_cyc[IN_LEN-1] + 1)
            check(!in_ready, "R7 flush block", longint'(in_ready), 0);
         if (out_valid && !seen) begin
            first_cyc[nout] = cyc;
            seen = 1'b1;
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = longint'(out_data);
         if (in_valid && in_ready) begin
            acc_cyc[idx] = cyc;
            idx++;
         end
         if (out_valid && out_ready) begin
            got[nout] = longint'(out_data);
            nout++;
            seen = 1'b0;
         end
         cyc++;
      end
      check(nout == OUT_LEN, "R2 output count", nout, OUT_LEN);
      for (int k = 0; k < nout; k++) begin
         longint exp = 0;
         for (int j = 0; j < SEG_LEN; j++) exp += elem(pat, k * SEG_LEN + j);
         check(got[k] == exp, "R1 run sum", got[k], exp);
      end
      if (timing && nout == OUT_LEN) begin
         for (int k = 0; k < OUT_LEN - 1; k++)
            check(first_cyc[k] == acc_cyc[(k+1)*SEG_LEN] + 1, "R4 mid emit timing",
                  first_cyc[k], acc_cyc[(k+1)*SEG_LEN] + 1);
         check(first_cyc[OUT_LEN-1] == acc_cyc[IN_LEN-1] + 2, "R5 final flush timing",
               first_cyc[OUT_LEN-1], acc_cyc[IN_LEN-1] + 2);
      end
      in_valid  = 1'b0;
      out_ready = 1'b1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         #1;
         if (out_valid) extra++;
      end
      check(extra == 0, "R2 no extra output", extra, 0);
   endtask

   task automatic t_reset;
      rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      check(!out_valid, "R8 reset valid", longint'(out_valid), 0);
      check(in_ready, "R8 reset ready", longint'(in_ready), 1);
   endtask

   task automatic t_ramp;        run_stream(0, 1'b0, 1'b0, 1'b1); endtask
   task automatic t_scrambled;   run_stream(2, 1'b0, 1'b0, 1'b1); endtask
   // R3: two streams back to back; the second must not inherit the first's totals.
   task automatic t_back_to_back;
      run_stream(3, 1'b0, 1'b0, 1'b1);
      run_stream(0, 1'b0, 1'b0, 1'b1);
      check(1'b1, "R3 streams independent", 0, 0);
   endtask
   task automatic t_gaps_stalls; run_stream(2, 1'b1, 1'b1, 1'b0); endtask
   task automatic t_stalls_only; run_stream(3, 1'b0, 1'b1, 1'b0); endtask
   // R9: all-ones input reaches the largest total without wrapping.
   task automatic t_max;         run_stream(1, 1'b0, 1'b1, 1'b0); endtask

   task automatic t_reset_mid;
      out_ready = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = DATA_W'(elem(3, i));
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      check(!out_valid && in_ready, "R8 mid-stream reset", longint'({out_valid, in_ready}), 1);
      run_stream(0, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      t_reset();
      t_ramp();
      t_scrambled();
      t_back_to_back();
      t_gaps_stalls();
      t_stalls_only();
      t_max();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule